// File: doc/BRIEF.md
# Serial Flash Header Sequencer

This block runs the front part of one serial flash transaction on a single-bit SPI bus. Software first writes three setup words through a simple write port: the flash address, a phase-length word and a data byte count. It then writes a command word that carries the opcode, a chip-select index and a few flags. Writing the command word launches the transaction. The sequencer pulls the selected active-low chip select low and shifts out the opcode, the address bytes and the dummy bytes. Every byte goes out MSB first at a programmable SCK rate.

When the header is done, the chip select is either released or held low so that a separate data engine can take over. The data byte count decides which. A status-read command sends its opcode once, then clocks one byte in from MISO and keeps it for software. Completion can raise an interrupt. A control write can abort everything at once.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset all chip selects are high, SCK is low, and busy, data_hold, irq and dummy_err are 0.
- R2: A write to offset 0x0C launches a header built from the address word (offset 0x00), the length word (offset 0x04) and the opcode in command bits 31:24. The header is sent in this order: the opcode repeated length-word bits 25:24 times, then the address bytes most significant first starting at byte (length bits 2:0 minus one), then (length bits 23:16 divided by 8) zero bytes.
- R3: The opcode repeat count is clamped to 2 and the address byte count is clamped to 4.
- R4: Bits leave MSB first on MOSI and are stable at each rising SCK edge. One SCK period lasts 2·(n+1) clock cycles, where n is bits 1:0 of the control word at offset 0x10. Control bit 4 selects mode 3, with SCK idling high; otherwise SCK idles low.
- R5: While busy, exactly one chip select is low: the one indexed by command bits 9:8.
- R6: After the header, chip select is released if the data count at offset 0x08 is zero. Otherwise it stays low and data_hold goes to 1.
- R7: Command bit 0 set makes header completion set interrupt status bit 0, and irq follows that bit. Writing 1 in bit 0 to offset 0x14 clears it.
- R8: A dummy clock count whose bits 2:0 are not all zero sets dummy_err from the cycle after launch until the next accepted command or abort.
- R9: Command bit 2 set with bit 1 clear is a status read: the opcode is sent once, then one zero byte is sent while MISO is sampled on rising SCK edges into stat_byte, and the length word is ignored. With bit 1 set, the command is a normal header.
- R10: A command-word write while busy is ignored; it changes neither the chip selects nor the byte stream.
- R11: A control write with bit 8 set clears all registers and state and raises all chip selects. The other control bits of that same write are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register byte offset |
| wr_data | input | 32 | Register write data |
| miso | input | 1 | Serial data from flash |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| cs_n | output | NUM_CS | Active-low chip selects |
| busy | output | 1 | Header phase running |
| data_hold | output | 1 | Chip select kept low for a data phase |
| irq | output | 1 | Interrupt request |
| dummy_err | output | 1 | Dummy count not a multiple of 8 |
| stat_byte | output | 8 | Last byte captured by a status read |

## Verification
A wrong phase counter shows up at once as an extra, missing or reordered byte on MOSI. The bench catches this within one byte time of the fault by comparing every completed byte against its expectation queue. A stuck or mis-decoded chip-select state appears on cs_n in the first cycle of busy. It also shows as a chip select left low after the header. Divider or polarity faults change the SCK spacing or the idle level and are measured within one bit period. A missed capture shows in stat_byte as soon as the status read ends.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
    localparam int BYTE_W  = 8;
    localparam int BIT_CW  = $clog2(BYTE_W);
    localparam int DIV_W   = 2;
    localparam int ILEN_W  = 2;
    localparam int ALEN_W  = 3;
    localparam int DCLK_W  = 8;
    localparam int DBYTE_W = DCLK_W - BIT_CW;
    localparam int MAX_INS = 2;
    localparam int MAX_ADR = 4;

    localparam logic [7:0] OFF_ADDR = 8'h00;
    localparam logic [7:0] OFF_LEN  = 8'h04;
    localparam logic [7:0] OFF_CNT  = 8'h08;
    localparam logic [7:0] OFF_CMD  = 8'h0C;
    localparam logic [7:0] OFF_CTRL = 8'h10;
    localparam logic [7:0] OFF_ISR  = 8'h14;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_st_e;

    function automatic logic [ILEN_W-1:0] clamp_ins(input logic [ILEN_W-1:0] v);
        return (v > ILEN_W'(MAX_INS)) ? ILEN_W'(MAX_INS) : v;
    endfunction

    function automatic logic [ALEN_W-1:0] clamp_adr(input logic [ALEN_W-1:0] v);
        return (v > ALEN_W'(MAX_ADR)) ? ALEN_W'(MAX_ADR) : v;
    endfunction
endpackage

// File: rtl/spi_bit_shifter.sv
`timescale 1ns/1ps
module spi_bit_shifter
    import spi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DIV_W-1:0]  half_n,
    input  logic              cpol,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              act,
    output logic              last,
    output logic [BYTE_W-1:0] rx_byte
);
    typedef struct packed {
        logic              act;
        logic              hi;
        logic [BIT_CW-1:0] bitc;
        logic [DIV_W-1:0]  hcnt;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
    } sh_t;

    sh_t s_q, s_d;
    logic tick;

    always_comb begin
        s_d  = s_q;
        tick = s_q.act && (s_q.hcnt == half_n);
        last = tick && s_q.hi && (s_q.bitc == '0);
        if (s_q.act) begin
            if (tick) begin
                s_d.hcnt = '0;
                if (!s_q.hi) begin
                    s_d.hi = 1'b1;
                    s_d.rx = {s_q.rx[BYTE_W-2:0], miso};
                end else if (s_q.bitc != '0) begin
                    s_d.hi   = 1'b0;
                    s_d.bitc = s_q.bitc - 1'b1;
                    s_d.tx   = {s_q.tx[BYTE_W-2:0], 1'b0};
                end else begin
                    s_d.act = 1'b0;
                    s_d.hi  = 1'b0;
                end
            end else begin
                s_d.hcnt = s_q.hcnt + 1'b1;
            end
        end
        if (start && (!s_q.act || last)) begin
            s_d.act  = 1'b1;
            s_d.hi   = 1'b0;
            s_d.bitc = BIT_CW'(BYTE_W - 1);
            s_d.hcnt = '0;
            s_d.tx   = tx_byte;
        end
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck     = s_q.act ? s_q.hi : cpol;
    assign mosi    = s_q.act ? s_q.tx[BYTE_W-1] : 1'b0;
    assign act     = s_q.act;
    assign rx_byte = s_q.rx;
endmodule

// File: rtl/spi_hdr_seq.sv
`timescale 1ns/1ps
module spi_hdr_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               go,
    input  logic [BYTE_W-1:0]  opcode,
    input  logic [CS_W-1:0]    cs_idx,
    input  logic               is_stat,
    input  logic [31:0]        addr,
    input  logic [ILEN_W-1:0]  ilen,
    input  logic [ALEN_W-1:0]  alen,
    input  logic [DCLK_W-1:0]  dclk,
    input  logic               keep_cs,
    input  logic               sh_act,
    input  logic               sh_last,
    input  logic [BYTE_W-1:0]  sh_rx,
    output logic               sh_start,
    output logic [BYTE_W-1:0]  sh_byte,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               busy,
    output logic               hold,
    output logic               fin,
    output logic [BYTE_W-1:0]  stat_byte
);
    typedef struct packed {
        seq_st_e            st;
        logic [ILEN_W-1:0]  ins;
        logic [ALEN_W-1:0]  adr;
        logic [DBYTE_W-1:0] dmy;
        logic               sts;
        logic               cur_sts;
        logic               keep;
        logic [BYTE_W-1:0]  opc;
        logic [31:0]        addr;
        logic [NUM_CS-1:0]  cs_n;
        logic               hold;
        logic [BYTE_W-1:0]  stat;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        fin      = 1'b0;
        sh_start = 1'b0;
        sh_byte  = '0;
        if (go) begin
            d.st      = SEQ_RUN;
            d.cs_n    = ~(NUM_CS'(1) << cs_idx);
            d.hold    = 1'b0;
            d.opc     = opcode;
            d.addr    = addr;
            d.keep    = keep_cs;
            d.cur_sts = 1'b0;
            if (is_stat) begin
                d.ins = ILEN_W'(1);
                d.adr = '0;
                d.dmy = '0;
                d.sts = 1'b1;
            end else begin
                d.ins = clamp_ins(ilen);
                d.adr = clamp_adr(alen);
                d.dmy = dclk[DCLK_W-1:BIT_CW];
                d.sts = 1'b0;
            end
        end else if (q.st == SEQ_RUN && (!sh_act || sh_last)) begin
            if (q.cur_sts && sh_last) d.stat = sh_rx;
            d.cur_sts = 1'b0;
            if (q.ins != '0) begin
                sh_start = 1'b1;
                sh_byte  = q.opc;
                d.ins    = q.ins - 1'b1;
            end else if (q.adr != '0) begin
                sh_start = 1'b1;
                sh_byte  = q.addr[{q.adr - 3'd1, 3'b000} +: BYTE_W];
                d.adr    = q.adr - 1'b1;
            end else if (q.dmy != '0) begin
                sh_start = 1'b1;
                d.dmy    = q.dmy - 1'b1;
            end else if (q.sts) begin
                sh_start  = 1'b1;
                d.sts     = 1'b0;
                d.cur_sts = 1'b1;
            end else begin
                d.st = SEQ_IDLE;
                fin  = 1'b1;
                if (q.keep) d.hold = 1'b1;
                else        d.cs_n = '1;
            end
        end
        if (clr) begin
            d      = '0;
            d.cs_n = '1;
            fin    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= '1;
        end else begin
            q <= d;
        end
    end

    assign cs_n      = q.cs_n;
    assign busy      = (q.st == SEQ_RUN);
    assign hold      = q.hold;
    assign stat_byte = q.stat;
endmodule

// File: rtl/spi_flash_seq.sv
`timescale 1ns/1ps
module spi_flash_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int REG_AW = 8,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic              busy,
    output logic              data_hold,
    output logic              irq,
    output logic              dummy_err,
    output logic [7:0]        stat_byte
);
    typedef struct packed {
        logic [31:0]       addr;
        logic [ILEN_W-1:0] ilen;
        logic [DCLK_W-1:0] dclk;
        logic [ALEN_W-1:0] alen;
        logic              cnt_nz;
        logic [DIV_W-1:0]  div;
        logic              mode3;
        logic              isr;
        logic              derr;
        logic              intr;
    } reg_t;

    reg_t r_q, r_d;
    logic go, abort, fin, busy_w;
    logic sh_act, sh_last, sh_start;
    logic [BYTE_W-1:0] sh_byte, sh_rx;
    logic cpol_w;
    logic [BIT_CW-1:0] dclk_frac_w;

    always_comb begin
        r_d   = r_q;
        go    = 1'b0;
        abort = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                REG_AW'(OFF_ADDR): r_d.addr = wr_data;
                REG_AW'(OFF_LEN): begin
                    r_d.ilen = wr_data[25:24];
                    r_d.dclk = wr_data[23:16];
                    r_d.alen = wr_data[2:0];
                end
                REG_AW'(OFF_CNT):  r_d.cnt_nz = |wr_data;
                REG_AW'(OFF_CMD):  go = !busy_w;
                REG_AW'(OFF_CTRL): begin
                    if (wr_data[8]) begin
                        r_d   = '0;
                        abort = 1'b1;
                    end
                    r_d.div   = wr_data[DIV_W-1:0];
                    r_d.mode3 = wr_data[4];
                end
                REG_AW'(OFF_ISR):  r_d.isr = r_q.isr & ~wr_data[0];
                default: ;
            endcase
        end
        if (go) begin
            r_d.derr = |r_q.dclk[BIT_CW-1:0];
            r_d.intr = wr_data[0];
        end
        if (fin && r_q.intr && !abort) r_d.isr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    spi_hdr_seq #(.NUM_CS(NUM_CS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (abort),
        .go        (go),
        .opcode    (wr_data[31:24]),
        .cs_idx    (wr_data[8 +: CS_W]),
        .is_stat   (wr_data[2] & ~wr_data[1]),
        .addr      (r_q.addr),
        .ilen      (r_q.ilen),
        .alen      (r_q.alen),
        .dclk      (r_q.dclk),
        .keep_cs   (r_q.cnt_nz),
        .sh_act    (sh_act),
        .sh_last   (sh_last),
        .sh_rx     (sh_rx),
        .sh_start  (sh_start),
        .sh_byte   (sh_byte),
        .cs_n      (cs_n),
        .busy      (busy_w),
        .hold      (data_hold),
        .fin       (fin),
        .stat_byte (stat_byte)
    );

    spi_bit_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (abort),
        .half_n  (r_q.div),
        .cpol    (r_q.mode3),
        .start   (sh_start),
        .tx_byte (sh_byte),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .act     (sh_act),
        .last    (sh_last),
        .rx_byte (sh_rx)
    );

    assign busy        = busy_w;
    assign irq         = r_q.isr;
    assign dummy_err   = r_q.derr;
    assign cpol_w      = r_q.mode3;
    assign dclk_frac_w = r_q.dclk[BIT_CW-1:0];
endmodule

// File: rtl/spi_flash_seq_chk.sv
`timescale 1ns/1ps
module spi_flash_seq_chk #(
    parameter int NUM_CS = 4,
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sck,
    input logic              busy,
    input logic              irq,
    input logic              dummy_err,
    input logic              mode3,
    input logic [2:0]        dclk_frac,
    input logic              fin,
    input logic              intr,
    input logic              sh_act,
    input logic              sh_last
);
    logic cmd_wr, ctrl_abort;
    assign cmd_wr     = wr_en && (wr_addr == REG_AW'(8'h0C));
    assign ctrl_abort = wr_en && (wr_addr == REG_AW'(8'h10)) && wr_data[8];

    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_busy_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(~cs_n) == 1));

    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == mode3));

    p_busy_cmd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && sh_act && !sh_last) |=> $stable(cs_n));

    p_abort_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_abort |=> (cs_n == '1) && !busy && !irq);

    p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && intr && !ctrl_abort) |=> irq);

    p_dummy_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && (dclk_frac != 3'd0)) |=> dummy_err);
endmodule

bind spi_flash_seq spi_flash_seq_chk #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cs_n      (cs_n),
    .sck       (sck),
    .busy      (busy),
    .irq       (irq),
    .dummy_err (dummy_err),
    .mode3     (cpol_w),
    .dclk_frac (dclk_frac_w),
    .fin       (fin),
    .intr      (r_q.intr),
    .sh_act    (sh_act),
    .sh_last   (sh_last)
);

// File: tb/spi_flash_seq_tb_top.sv
`timescale 1ns/1ps
module spi_flash_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        miso;
    logic        sck, mosi, busy, data_hold, irq, dummy_err;
    logic [3:0]  cs_n;
    logic [7:0]  stat_byte;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      cur_tag = "R2";
    logic [7:0] sl_pat = 8'hA5;
    logic [2:0] bi = '0;
    logic [7:0] shreg = '0;
    logic       sck_prev = 1'b0;
    int         since_rise = 0;
    int         last_period = 0;

    always #2.5 clk = ~clk;

    spi_flash_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .miso(miso), .sck(sck), .mosi(mosi),
        .cs_n(cs_n), .busy(busy), .data_hold(data_hold), .irq(irq),
        .dummy_err(dummy_err), .stat_byte(stat_byte)
    );

    assign miso = sl_pat[3'd7 - bi];

    task automatic chk(input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: rebuild bytes from MOSI at rising SCK, compare with scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            since_rise++;
            if (cs_n == 4'hF) begin
                bi = '0;
            end else if (sck && !sck_prev) begin
                shreg       = {shreg[6:0], mosi};
                last_period = since_rise;
                since_rise  = 0;
                if (bi == 3'd7) begin
                    if (exp_q.size() == 0) chk(cur_tag, "unexpected byte", shreg, -1);
                    else                   chk(cur_tag, "byte", shreg, exp_q.pop_front());
                    bi = '0;
                end else begin
                    bi = bi + 1'b1;
                end
            end
            sck_prev = sck;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic push_hdr(input logic [31:0] a, input logic [31:0] len,
                            input logic [7:0] opc, input bit stat);
        int il, al, nd;
        if (stat) begin
            exp_q.push_back(opc);
            exp_q.push_back(8'h00);
        end else begin
            il = (len[25:24] > 2) ? 2 : int'(len[25:24]);
            al = (len[2:0] > 4) ? 4 : int'(len[2:0]);
            nd = int'(len[23:16]) / 8;
            for (int i = 0; i < il; i++) exp_q.push_back(opc);
            for (int i = al - 1; i >= 0; i--) exp_q.push_back(a[i*8 +: 8]);
            for (int i = 0; i < nd; i++) exp_q.push_back(8'h00);
        end
    endtask

    task automatic run_cmd(input string tag, input logic [31:0] a,
                           input logic [31:0] len, input logic [31:0] cnt,
                           input logic [31:0] cmd);
        cur_tag = tag;
        wr(8'h00, a);
        wr(8'h04, len);
        wr(8'h08, cnt);
        push_hdr(a, len, cmd[31:24], cmd[2] && !cmd[1]);
        wr(8'h0C, cmd);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("WD", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [3:0] cs_snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n", cs_n, 4'hF);
        chk("R1", "sck", sck, 0);
        chk("R1", "busy/hold/irq/err", {busy, data_hold, irq, dummy_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R5/R7 basic header, cs 2, interrupt on
        wr(8'h10, 32'h0);
        run_cmd("R2", 32'h44332211, 32'h01080003, 32'h0, 32'h0B000201);
        chk("R5", "cs_n during header", cs_n, 4'b1011);
        chk("R5", "busy", busy, 1);
        wait_idle();
        chk("R2", "bytes left", exp_q.size(), 0);
        chk("R4", "sck period n=0", last_period, 2);
        chk("R6", "cs released", cs_n, 4'hF);
        chk("R6", "hold", data_hold, 0);
        chk("R7", "irq set", irq, 1);
        wr(8'h14, 32'h1);
        chk("R7", "irq cleared", irq, 0);

        // R3 clamps, divider n=2
        wr(8'h10, 32'h2);
        run_cmd("R3", 32'hA1B2C3D4, 32'h03000007, 32'h0, 32'h9F000000);
        wait_idle();
        chk("R3", "bytes left", exp_q.size(), 0);
        chk("R4", "sck period n=2", last_period, 6);
        chk("R7", "no irq without flag", irq, 0);

        // R8 dummy not multiple of 8
        run_cmd("R8", 32'h0, 32'h000C0000, 32'h0, 32'h00000000);
        chk("R8", "dummy_err after launch", dummy_err, 1);
        wait_idle();
        chk("R8", "bytes left", exp_q.size(), 0);
        run_cmd("R8", 32'h0, 32'h01000000, 32'h0, 32'h12000000);
        chk("R8", "dummy_err cleared", dummy_err, 0);
        wait_idle();

        // R6 data pending keeps cs low
        run_cmd("R6", 32'h0, 32'h01000000, 32'h4, 32'h06000300);
        wait_idle();
        chk("R6", "cs held", cs_n, 4'b0111);
        chk("R6", "hold flag", data_hold, 1);
        chk("R6", "bytes left", exp_q.size(), 0);

        // R9 status read, length word ignored
        run_cmd("R9", 32'h0, 32'h02FF0004, 32'h0, 32'h05000104);
        chk("R5", "cs moved to 1", cs_n, 4'b1101);
        wait_idle();
        chk("R9", "bytes left", exp_q.size(), 0);
        chk("R9", "stat_byte", stat_byte, 8'hA5);
        chk("R9", "cs released", cs_n, 4'hF);
        sl_pat = 8'h3C;
        run_cmd("R9", 32'h0, 32'h01000000, 32'h0, 32'h05000106);
        wait_idle();
        chk("R9", "write flag: normal header", exp_q.size(), 0);
        chk("R9", "stat_byte kept", stat_byte, 8'hA5);

        // R10 command while busy ignored
        run_cmd("R10", 32'hCAFE0102, 32'h01000004, 32'h0, 32'h03000000);
        repeat (6) @(negedge clk);
        cs_snap = cs_n;
        wr(8'h0C, 32'hEE000301);
        chk("R10", "cs unchanged", cs_n, cs_snap);
        chk("R10", "still busy", busy, 1);
        wait_idle();
        chk("R10", "no extra bytes", exp_q.size(), 0);
        chk("R10", "no irq from ignored write", irq, 0);

        // R4 mode 3
        wr(8'h10, 32'h10);
        chk("R4", "mode3 idle high", sck, 1);
        run_cmd("R4", 32'h0, 32'h01000000, 32'h0, 32'h3C000000);
        wait_idle();
        chk("R4", "mode3 byte", exp_q.size(), 0);
        chk("R4", "mode3 period", last_period, 2);
        chk("R4", "mode3 idle after", sck, 1);

        // R11 abort
        run_cmd("R11", 32'h0, 32'h01000000, 32'h0, 32'h11000001);
        wait_idle();
        chk("R7", "irq before abort", irq, 1);
        wr(8'h10, 32'h3);
        run_cmd("R11", 32'h01020304, 32'h01400004, 32'h0, 32'h22000001);
        repeat (20) @(negedge clk);
        wr(8'h10, 32'h101);
        exp_q.delete();
        chk("R11", "cs_n", cs_n, 4'hF);
        chk("R11", "busy", busy, 0);
        chk("R11", "irq", irq, 0);
        chk("R11", "sck idle low", sck, 0);
        wr(8'h04, 32'h01000000);
        wr(8'h08, 32'h0);
        cur_tag = "R11";
        push_hdr(32'h0, 32'h01000000, 8'h77, 0);
        wr(8'h0C, 32'h77000000);
        wait_idle();
        chk("R11", "kept divider n=1", last_period, 4);
        chk("R11", "bytes left", exp_q.size(), 0);

        finish_run();
    end
endmodule